// File: doc/BRIEF.md
# Encode-Cycle Phase Sequencer

The sequencer drives the control strobes of a gain-ranged sampling front end for each conversion cycle. A fast internal clock runs at a fixed multiple of the encode rate. The encode input is sampled in that clock domain. Each rising encode edge restarts a phase counter. The counter splits the encode period into quarters, and those quarters set the track-and-hold state, the peak-detector calibration window, the discharge of the shared noise filter, and the enable of the amplifier that drives the filter.

The block also picks the input channel for each cycle. Two select pins choose channel A alone, channel B alone, alternation between A and B on successive encodes, or an idle state in which the amplifier stays off. The mode and channel are latched only at an encode edge. A select change in the middle of a cycle therefore takes effect at the next conversion.

Top module: `enc_phase_seq`

## Requirements
- R1: While reset is asserted, and after reset until the first encode rising edge, hold_o, cal_o, discharge_o, amp_en_o and chan_b_o are 0 and phase_o is 0.
- R2: In the clock after an encode rising edge is sampled (enc_i high, previously low), hold_o rises. With RATIO=8 it stays high for phases 0 to 3 and is low in phases 4 to 7.
- R3: cal_o is high for exactly the first quarter of the cycle (phases 0 and 1), starting in the clock after the encode rising edge.
- R4: discharge_o is high in exactly the same clocks as cal_o.
- R5: amp_en_o is 0 in phases 0 to 3 and 1 in phases 4 to 7 whenever the latched mode is not idle.
- R6: If no new encode edge arrives, phase_o saturates at 7 and the block stays in the amplifier-settling state (amp_en_o 1, hold_o 0, cal_o 0).
- R7: An encode rising edge in any phase restarts the sequence at phase 0 in the next clock.
- R8: The select pins are sampled only at an encode rising edge. sel_a_i=1, sel_b_i=0 gives chan_b_o=0. sel_a_i=0, sel_b_i=1 gives chan_b_o=1. A select change between edges has no effect on any output until the next edge.
- R9: With both selects high, chan_b_o alternates on each encode edge. It starts with channel A (chan_b_o=0) on the first dual-mode edge after any non-dual cycle or reset.
- R10: With both selects low at an encode edge, amp_en_o stays 0 for the whole cycle, chan_b_o is 0, and the dual-mode alternation is reset to channel A.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Internal clock, RATIO times the encode rate |
| rst_ni | input | 1 | Asynchronous active-low reset |
| enc_i | input | 1 | Encode signal, synchronous to clk_i |
| sel_a_i | input | 1 | Channel A select |
| sel_b_i | input | 1 | Channel B select |
| hold_o | output | 1 | Track-and-hold in hold |
| cal_o | output | 1 | Peak-detector calibration window |
| discharge_o | output | 1 | Noise-filter discharge strobe |
| amp_en_o | output | 1 | Filter driver amplifier enable |
| chan_b_o | output | 1 | Channel for this cycle (0 = A, 1 = B) |
| phase_o | output | $clog2(RATIO) | Current phase within the encode cycle |

## Verification
An encode edge can land in the same clock as a select change, and it can also arrive before the settling phase has ended. The bench provokes the first case by changing the selects on the same clock that raises enc_i. It provokes the second by using 6-clock encode periods and by moving the selects in the middle of a cycle. A behavioural model that is updated on every clock judges each output. Any disagreement is reported against the requirement that owns that output: the restart must win over the settling phase, and the new mode must apply from that very edge.

// File: rtl/enc_seq_pkg.sv
`timescale 1ns/1ps
package enc_seq_pkg;
  // Encoding is {sel_b, sel_a}
  typedef enum logic [1:0] {
    MODE_IDLE = 2'b00,
    MODE_A    = 2'b01,
    MODE_B    = 2'b10,
    MODE_DUAL = 2'b11
  } mode_e;

  function automatic mode_e decode_mode(input logic sel_a, input logic sel_b);
    return mode_e'({sel_b, sel_a});
  endfunction
endpackage

// File: rtl/enc_edge_det.sv
`timescale 1ns/1ps
module enc_edge_det (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic enc_i,
  output logic rise_o
);
  logic enc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) enc_q <= 1'b0;
    else         enc_q <= enc_i;
  end

  assign rise_o = enc_i & ~enc_q;
endmodule

// File: rtl/enc_phase_ctr.sv
`timescale 1ns/1ps
module enc_phase_ctr #(
  parameter int RATIO = 8,
  localparam int PW = $clog2(RATIO)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          rise_i,
  output logic [PW-1:0] phase_o,
  output logic          run_o
);
  localparam logic [PW-1:0] LAST = PW'(RATIO - 1);

  logic [PW-1:0] phase_q;
  logic          run_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= '0;
      run_q   <= 1'b0;
    end else if (rise_i) begin
      phase_q <= '0;
      run_q   <= 1'b1;
    end else if (run_q && phase_q != LAST) begin
      phase_q <= phase_q + 1'b1;
    end
  end

  assign phase_o = phase_q;
  assign run_o   = run_q;

  // Without a new edge the counter parks in the final phase
  assert_phase_sat_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_q && !rise_i && phase_q == LAST) |=> (phase_q == LAST));

  assert_restart_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise_i |=> (phase_q == '0 && run_q));
endmodule

// File: rtl/enc_chan_sel.sv
`timescale 1ns/1ps
module enc_chan_sel
  import enc_seq_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  rise_i,
  input  logic  sel_a_i,
  input  logic  sel_b_i,
  output mode_e mode_o,
  output logic  chan_b_o
);
  mode_e mode_q, mode_d;
  logic  chan_q, tgl_q;

  assign mode_d = decode_mode(sel_a_i, sel_b_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= MODE_IDLE;
      chan_q <= 1'b0;
      tgl_q  <= 1'b0;
    end else if (rise_i) begin
      mode_q <= mode_d;
      unique case (mode_d)
        MODE_DUAL: begin
          chan_q <= tgl_q;
          tgl_q  <= ~tgl_q;
        end
        MODE_B: begin
          chan_q <= 1'b1;
          tgl_q  <= 1'b0;
        end
        default: begin
          chan_q <= 1'b0;
          tgl_q  <= 1'b0;
        end
      endcase
    end
  end

  assign mode_o   = mode_q;
  assign chan_b_o = chan_q;

  assert_single_chan_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rise_i && sel_a_i != sel_b_i) |=> (chan_b_o == $past(sel_b_i)));

  assert_chan_stable_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rise_i |=> $stable(chan_b_o));

  assert_idle_chan_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rise_i && !sel_a_i && !sel_b_i) |=> !chan_b_o);
endmodule

// File: rtl/enc_phase_seq.sv
`timescale 1ns/1ps
module enc_phase_seq
  import enc_seq_pkg::*;
#(
  parameter int RATIO = 8
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     enc_i,
  input  logic                     sel_a_i,
  input  logic                     sel_b_i,
  output logic                     hold_o,
  output logic                     cal_o,
  output logic                     discharge_o,
  output logic                     amp_en_o,
  output logic                     chan_b_o,
  output logic [$clog2(RATIO)-1:0] phase_o
);
  localparam int PW = $clog2(RATIO);
  localparam int QTR = RATIO / 4;
  localparam logic [PW-1:0] CAL_END = PW'(QTR);
  localparam logic [PW-1:0] AMP_ON  = PW'(2 * QTR);

  logic          rise;
  logic          run;
  logic [PW-1:0] phase;
  mode_e         mode;

  enc_edge_det u_edge (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .enc_i (enc_i),
    .rise_o(rise)
  );

  enc_phase_ctr #(.RATIO(RATIO)) u_ctr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .rise_i (rise),
    .phase_o(phase),
    .run_o  (run)
  );

  enc_chan_sel u_chan (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .rise_i  (rise),
    .sel_a_i (sel_a_i),
    .sel_b_i (sel_b_i),
    .mode_o  (mode),
    .chan_b_o(chan_b_o)
  );

  // Quarter 0: calibrate + discharge; quarter 1: quiet; quarters 2-3: settle
  assign cal_o       = run && (phase < CAL_END);
  assign discharge_o = run && (phase < CAL_END);
  assign hold_o      = run && (phase < AMP_ON);
  assign amp_en_o    = run && (phase >= AMP_ON) && (mode != MODE_IDLE);
  assign phase_o     = phase;

  assert_enc_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise |=> (hold_o && cal_o));

  assert_cal_discharge_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cal_o |-> (discharge_o && !amp_en_o));

  assert_amp_quiet_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    amp_en_o |-> (!hold_o && !discharge_o));

  assert_idle_amp_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rise && !sel_a_i && !sel_b_i) |=> !amp_en_o);

  assert_reset_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run |-> (!hold_o && !cal_o && !amp_en_o));
endmodule

// File: tb/enc_phase_seq_tb_top.sv
`timescale 1ns/1ps
module enc_phase_seq_tb_top;
  logic clk = 1'b0, rst_n = 1'b0, enc = 1'b0, sa = 1'b0, sb = 1'b0;
  logic hold, cal, dis, amp, chb;
  logic [2:0] ph;
  int vectors = 0, misses = 0;
  bit checking = 0;

  always #2.5 clk = ~clk;

  enc_phase_seq #(.RATIO(8)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .enc_i(enc), .sel_a_i(sa), .sel_b_i(sb),
    .hold_o(hold), .cal_o(cal), .discharge_o(dis), .amp_en_o(amp),
    .chan_b_o(chb), .phase_o(ph)
  );

  // Behavioural reference
  int m_ph;
  bit m_run, m_prev, m_tgl, m_chan, m_idle, m_dual, rise;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_ph = 0; m_run = 0; m_prev = 0; m_tgl = 0; m_chan = 0; m_idle = 1; m_dual = 0;
    end else begin
      rise = enc && !m_prev;
      if (rise) begin
        m_ph = 0; m_run = 1;
        m_idle = !sa && !sb;
        m_dual = sa && sb;
        if (m_dual) begin m_chan = m_tgl; m_tgl = !m_tgl; end
        else begin m_chan = sb && !sa; m_tgl = 0; end
      end else if (m_run && m_ph < 7) m_ph++;
      m_prev = enc;
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    vectors++;
    if (act !== exp) begin
      misses++;
      $display("FAIL %s act=%0d exp=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (checking) begin
    chk("R2 hold", hold, m_run && m_ph < 4);
    chk("R3 cal", cal, m_run && m_ph < 2);
    chk("R4 discharge", dis, m_run && m_ph < 2);
    chk(m_idle ? "R10 amp" : "R5 amp", amp, m_run && m_ph >= 4 && !m_idle);
    chk(m_dual ? "R9 chan" : "R8 chan", chb, m_chan);
    chk("R7 phase", ph, m_ph);
  end

  task automatic enc_pulse(input int period);
    enc = 1;
    repeat (period / 2) @(negedge clk);
    enc = 0;
    repeat (period - period / 2) @(negedge clk);
  endtask

  initial begin
    #1;
    // R1: outputs quiet in reset
    chk("R1 reset", {hold, cal, dis, amp, chb, ph}, 0);
    repeat (2) @(negedge clk);
    rst_n = 1;
    checking = 1;
    repeat (3) @(negedge clk);
    chk("R1 pre-encode", {hold, cal, dis, amp}, 0);

    // R8: channel A only, select changes with encode edge
    sa = 1; sb = 0;
    repeat (3) enc_pulse(8);
    sa = 0; sb = 1;
    repeat (2) enc_pulse(8);
    // R8: mid-cycle select change ignored until next edge
    enc = 1; @(negedge clk); @(negedge clk);
    sa = 1; sb = 0;
    chk("R8 midcycle", chb, 1);
    enc = 0; repeat (6) @(negedge clk);
    chk("R8 midcycle end", chb, 1);
    enc_pulse(8);
    chk("R8 after edge", chb, 0);

    // R9: dual alternation starting at A
    sa = 1; sb = 1;
    for (int i = 0; i < 5; i++) begin
      enc_pulse(8);
      chk("R9 alternate", chb, i % 2);
    end
    // R10: idle
    sa = 0; sb = 0;
    repeat (2) enc_pulse(8);
    chk("R10 idle chan", chb, 0);
    // R9: restart from A after idle
    sa = 1; sb = 1;
    enc_pulse(8);
    chk("R9 restart", chb, 0);
    // R7: short periods restart early
    repeat (4) enc_pulse(6);
    repeat (3) enc_pulse(5);
    // R6: long gap saturates
    sa = 1; sb = 0;
    enc = 1; @(negedge clk); enc = 0;
    repeat (14) @(negedge clk);
    chk("R6 saturate", ph, 7);
    chk("R6 settle", {amp, hold, cal}, 3'b100);
    repeat (2) enc_pulse(8);
    checking = 0;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end

  initial begin
    #(200000 * 5);
    misses++;
    $display("FAIL watchdog act=0 exp=1");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end
endmodule